// File: doc/BRIEF.md
# Serial Wiper Setting Interface

This block is a three-wire serial slave that owns one 8-bit wiper setting for a programmable voltage divider. A host drives a serial clock, a select line and a data line. The block answers on a data-out line that is driven only while the block is selected. It runs from a faster system clock: the serial clock, select, data and program-enable pins are synchronized, and serial clock rising edges are detected from the synchronized copy.

A working register drives the output code. Each frame carries a start bit, a two-bit address and eight data bits, all least significant bit first. While the data bits arrive, the old contents of the working register leave on the data-out line, so every transaction reads back the setting. A frame with the matching address replaces the working value. Releasing the select line for long enough restores the working register from the stored non-volatile value. This lets a trial setting be applied and then dropped. If the program-enable pin is high when the frame is committed, the block sends a one-cycle write request with the new value to the separate non-volatile store.

Top module: `wiper_serial_if`

## Requirements
- R1: The data-out enable is 0 while the filtered select is inactive. It becomes 1 once the select line is high. While the enable is 0, the data-out value is 0.
- R2: A frame is a 1 start bit, then address bits A0 and A1, then data bits D0 to D7, each sampled on a serial clock rising edge. With A0=1 and A1=0 (address value 1), the data byte becomes the new output code.
- R3: The output code keeps its old value through the D7 edge. It takes the new value after the next serial clock rising edge.
- R4: During the cycle in which data bit Dk is presented, data-out shows bit k of the output code as it stood when the frame began.
- R5: A frame with any address other than value 1 leaves the output code unchanged. It still shifts the current code out on data-out.
- R6: While the filtered select is inactive, the output code equals the stored value input, so a temporary setting is discarded.
- R7: A low pulse on the select line that is shorter than CS_FILT system clock samples leaves the block selected and keeps its working value.
- R8: The two serial clock edges after D7 form a gap in which a 1 on the data line is not taken as a start bit. A start bit on the third edge after D7 is accepted.
- R9: If program-enable is high at the first edge after D7 of a matching frame, the block sends a write request for exactly one system cycle, carrying the new byte. If program-enable is low, no request is sent.
- R10: While no frame is in progress, 0 bits on the data line are ignored.
- R11: After reset the output code equals the stored value input, the data-out enable is 0 and no write request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock pin |
| ser_cs | input | 1 | Select pin, active high |
| ser_di | input | 1 | Serial data in |
| ser_prog | input | 1 | Program-enable pin |
| nv_value | input | 8 | Value held by the non-volatile store |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the data-out pad driver |
| wiper_code | output | 8 | Current output code |
| nv_wr_req | output | 1 | One-cycle request to store a new value |
| nv_wr_data | output | 8 | Value to store, valid with the request |

## Verification
The assertions assume that the serial pins change slowly relative to the system clock. Each serial clock phase must last several system cycles, so that every serial edge passes the synchronizer and is seen exactly once. They also assume that program-enable is stable around the first edge after D7. The bench drives every pin on the falling system clock edge and holds each serial clock phase for six system cycles. It holds program-enable for the whole frame and its gap. It makes select glitches only between frames, where the short low pulse cannot cut into a transfer.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int WIPER_W = 8;
    localparam int ADDR_W  = 2;
    localparam int CNT_W   = $clog2(WIPER_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_GAP
    } fr_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [WIPER_W-1:0] data;
    } frame_t;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] self);
        return a == self;
    endfunction

    function automatic logic [WIPER_W-1:0] shift_in_data(input logic [WIPER_W-1:0] v,
                                                         input logic b);
        return {b, v[WIPER_W-1:1]};
    endfunction

    function automatic logic [ADDR_W-1:0] shift_in_addr(input logic [ADDR_W-1:0] v,
                                                        input logic b);
        return {b, v[ADDR_W-1:1]};
    endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wiper_cs_filter.sv
module wiper_cs_filter #(
    parameter int FILT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_in,
    output logic active
);
    localparam int CW = $clog2(FILT + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            low_cnt <= '0;
        end else if (cs_in) begin
            active  <= 1'b1;
            low_cnt <= '0;
        end else if (active) begin
            if (low_cnt == CW'(FILT - 1)) begin
                active  <= 1'b0;
                low_cnt <= '0;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    AST_CS_RISE_FAST: assert property (@(posedge clk) disable iff (rst)
        cs_in |=> active); // R1

    AST_CS_DROP_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> !$past(cs_in)); // R7
endmodule

// File: rtl/wiper_frame_fsm.sv
module wiper_frame_fsm
    import wiper_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SELF_ADDR = 2'b01,
    parameter int                GAP_CLKS  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               ser_rise,
    input  logic               ser_di,
    input  logic               prog,
    input  logic [WIPER_W-1:0] cur_code,
    output logic               commit_vld,
    output logic [WIPER_W-1:0] commit_data,
    output logic               wr_req,
    output logic               do_bit
);
    localparam int GW = $clog2(GAP_CLKS + 1);

    fr_state_e          state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [GW-1:0]      gap_cnt;
    frame_t             rx;
    logic [WIPER_W-1:0] out_sr;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            gap_cnt    <= '0;
            rx         <= '0;
            out_sr     <= '0;
            commit_vld <= 1'b0;
            wr_req     <= 1'b0;
        end else begin
            commit_vld <= 1'b0;
            wr_req     <= 1'b0;
            if (ser_rise) begin
                unique case (state)
                    ST_IDLE: begin
                        if (ser_di) begin
                            state   <= ST_ADDR;
                            bit_cnt <= '0;
                        end
                    end
                    ST_ADDR: begin
                        rx.addr <= shift_in_addr(rx.addr, ser_di);
                        if (bit_cnt == CNT_W'(ADDR_W - 1)) begin
                            state   <= ST_DATA;
                            bit_cnt <= '0;
                            out_sr  <= cur_code;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        rx.data <= shift_in_data(rx.data, ser_di);
                        if (bit_cnt == CNT_W'(WIPER_W - 1)) begin
                            state   <= ST_GAP;
                            bit_cnt <= '0;
                            gap_cnt <= '0;
                            out_sr  <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            out_sr  <= out_sr >> 1;
                        end
                    end
                    ST_GAP: begin
                        if (gap_cnt == '0) begin
                            commit_vld <= addr_hit(rx.addr, SELF_ADDR);
                            wr_req     <= addr_hit(rx.addr, SELF_ADDR) && prog;
                        end
                        if (gap_cnt == GW'(GAP_CLKS - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign commit_data = rx.data;
    assign do_bit      = out_sr[0];

    AST_COMMIT_IN_GAP: assert property (@(posedge clk) disable iff (rst)
        commit_vld |-> (state == ST_GAP || state == ST_IDLE)); // R3

    AST_REQ_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> commit_vld); // R9

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> !wr_req); // R9

    AST_GAP_NO_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && ser_rise && active) |=> state != ST_ADDR); // R8

    AST_DO_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !do_bit); // R4
endmodule

// File: rtl/wiper_serial_if.sv
module wiper_serial_if
    import wiper_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                CS_FILT     = 4,
    parameter int                GAP_CLKS    = 2,
    parameter logic [ADDR_W-1:0] SELF_ADDR   = 2'b01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk,
    input  logic               ser_cs,
    input  logic               ser_di,
    input  logic               ser_prog,
    input  logic [WIPER_W-1:0] nv_value,
    output logic               sdo,
    output logic               sdo_oe,
    output logic [WIPER_W-1:0] wiper_code,
    output logic               nv_wr_req,
    output logic [WIPER_W-1:0] nv_wr_data
);
    logic [3:0]         pins_s;
    logic               sclk_s, cs_s, di_s, prog_s;
    logic               sclk_q, sclk_rise;
    logic               cs_act;
    logic               commit_vld, do_bit;
    logic [WIPER_W-1:0] commit_data;
    logic [WIPER_W-1:0] wiper_q;

    wiper_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_prog, ser_di, ser_cs, ser_clk}),
        .q   (pins_s)
    );

    assign {prog_s, di_s, cs_s, sclk_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_q;

    wiper_cs_filter #(.FILT(CS_FILT)) i_cs_filter (
        .clk    (clk),
        .rst    (rst),
        .cs_in  (cs_s),
        .active (cs_act)
    );

    wiper_frame_fsm #(.SELF_ADDR(SELF_ADDR), .GAP_CLKS(GAP_CLKS)) i_frame (
        .clk         (clk),
        .rst         (rst),
        .active      (cs_act),
        .ser_rise    (sclk_rise),
        .ser_di      (di_s),
        .prog        (prog_s),
        .cur_code    (wiper_q),
        .commit_vld  (commit_vld),
        .commit_data (commit_data),
        .wr_req      (nv_wr_req),
        .do_bit      (do_bit)
    );

    always_ff @(posedge clk) begin
        if (rst || !cs_act) wiper_q <= nv_value;
        else if (commit_vld) wiper_q <= commit_data;
    end

    assign wiper_code = wiper_q;
    assign nv_wr_data = commit_data;
    assign sdo_oe     = cs_act;
    assign sdo        = cs_act & do_bit;

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cs_act && !commit_vld) |=> $stable(wiper_q)); // R5

    AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo); // R1
endmodule

// File: tb/test_wiper_serial_if.sv
module test_wiper_serial_if;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0, ser_cs = 1'b0, ser_di = 1'b0, ser_prog = 1'b0;
    logic [7:0] nv_store;
    logic       sdo, sdo_oe, nv_wr_req;
    logic [7:0] wiper_code, nv_wr_data;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    logic [7:0] last_req;
    bit done = 0;

    always #4 clk = ~clk;

    wiper_serial_if i_wiper_serial_if (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_cs(ser_cs), .ser_di(ser_di),
        .ser_prog(ser_prog), .nv_value(nv_store), .sdo(sdo), .sdo_oe(sdo_oe),
        .wiper_code(wiper_code), .nv_wr_req(nv_wr_req), .nv_wr_data(nv_wr_data)
    );

    always @(posedge clk) begin
        if (rst) nv_store <= 8'h5A;
        else if (nv_wr_req) begin
            nv_store <= nv_wr_data;
            last_req <= nv_wr_data;
            req_cnt  <= req_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ser_bit(input logic b, output logic dob);
        ser_di = b;
        repeat (HALF) @(negedge clk);
        dob = sdo;
        ser_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [1:0] a, input logic [7:0] d, input logic p,
                              input logic g0, input logic g1,
                              output logic [7:0] rd, output logic [7:0] at_d7);
        logic dob;
        ser_prog = p;
        ser_bit(1'b1, dob);
        ser_bit(a[0], dob);
        ser_bit(a[1], dob);
        for (int k = 0; k < 8; k++) begin
            ser_bit(d[k], dob);
            rd[k] = dob;
        end
        at_d7 = wiper_code;
        ser_bit(g0, dob);
        ser_bit(g1, dob);
        ser_prog = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 code", wiper_code, 8'h5A);
        chk("R11 oe", sdo_oe, 0);
        chk("R11 req", req_cnt, 0);
        chk("R1 sdo idle", sdo, 0);
    endtask

    task automatic t_select_write();
        logic [7:0] rd, d7;
        ser_cs = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 oe on select", sdo_oe, 1);
        send_frame(2'b01, 8'h3C, 1'b0, 1'b0, 1'b0, rd, d7);
        chk("R4 readback", rd, 8'h5A);
        chk("R3 code held at D7", d7, 8'h5A);
        chk("R2 new code", wiper_code, 8'h3C);
        chk("R9 no req without prog", req_cnt, 0);
    endtask

    task automatic t_destructive_read();
        logic [7:0] rd, d7;
        send_frame(2'b01, 8'hC3, 1'b0, 1'b0, 1'b0, rd, d7);
        chk("R4 old value out", rd, 8'h3C);
        chk("R2 second write", wiper_code, 8'hC3);
    endtask

    task automatic t_other_addr();
        logic [7:0] rd, d7;
        send_frame(2'b10, 8'hFF, 1'b1, 1'b0, 1'b0, rd, d7);
        chk("R5 readback", rd, 8'hC3);
        chk("R5 code kept", wiper_code, 8'hC3);
        chk("R9 no req other addr", req_cnt, 0);
    endtask

    task automatic t_glitch();
        ser_cs = 1'b0;
        repeat (2) @(negedge clk);
        ser_cs = 1'b1;
        repeat (12) @(negedge clk);
        chk("R7 code kept", wiper_code, 8'hC3);
        chk("R7 still selected", sdo_oe, 1);
    endtask

    task automatic t_deselect();
        ser_cs = 1'b0;
        repeat (20) @(negedge clk);
        chk("R6 reload", wiper_code, 8'h5A);
        chk("R1 oe off", sdo_oe, 0);
        chk("R1 sdo off", sdo, 0);
    endtask

    task automatic t_gap();
        logic [7:0] rd, d7;
        logic dob;
        ser_cs = 1'b1;
        repeat (6) @(negedge clk);
        send_frame(2'b01, 8'h11, 1'b0, 1'b1, 1'b1, rd, d7);
        chk("R8 frame before gap", wiper_code, 8'h11);
        for (int i = 0; i < 12; i++) ser_bit(1'b0, dob);
        chk("R8 gap ones ignored", wiper_code, 8'h11);
        chk("R10 idle zeros", wiper_code, 8'h11);
        send_frame(2'b01, 8'h96, 1'b0, 1'b0, 1'b0, rd, d7);
        send_frame(2'b01, 8'h69, 1'b0, 1'b0, 1'b0, rd, d7);
        chk("R8 back-to-back read", rd, 8'h96);
        chk("R8 back-to-back code", wiper_code, 8'h69);
    endtask

    task automatic t_program();
        logic [7:0] rd, d7;
        send_frame(2'b01, 8'h77, 1'b1, 1'b0, 1'b0, rd, d7);
        chk("R9 one req", req_cnt, 1);
        chk("R9 req data", last_req, 8'h77);
        chk("R2 code", wiper_code, 8'h77);
        ser_cs = 1'b0;
        repeat (20) @(negedge clk);
        chk("R6 reload stored", wiper_code, 8'h77);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_select_write();
        t_destructive_read();
        t_other_addr();
        t_glitch();
        t_deselect();
        t_gap();
        t_program();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule